// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating counters. Each table entry is chosen by a few low-order bits of the branch address. Each entry holds one counter for every possible pattern of the most recent global branch outcomes. A global outcome shift register picks which counter of the entry gives the guess. As a result, the prediction for one branch depends on the path that other branches took to reach it.

The fetch side presents a branch address on the predict port and reads a taken/not-taken answer in the same cycle. The answer comes from combinational logic over registered state. When a branch resolves, the back end presents its address and real outcome on the update port. At the next clock edge the selected counter steps toward that outcome and the outcome is shifted into the global history. The default configuration uses two history bits, two-bit counters and sixteen address-indexed entries. Setting the history width to zero gives a plain two-bit counter table.

Top module: `corr_predictor`

## Requirements
- R1: After reset, and again after any later reset, every counter holds 1 (weakly not-taken, on the scale 0..3) and the global history is 0. Every address then predicts not-taken.
- R2: The counter index is {address bits [5:2], history[1:0]}, with the address bits in the upper part. The prediction is bit 1 (the MSB) of the selected counter: 1 means taken.
- R3: A taken update adds one to the selected counter and stops at 3. A not-taken update subtracts one and stops at 0.
- R4: Hysteresis: a counter at 3 still predicts taken after one not-taken update. A counter at 2 that receives a not-taken update predicts not-taken.
- R5: Each update shifts the history left by one and places the resolved outcome in bit 0 (1 = taken). Bit 1 therefore holds the older of the two outcomes.
- R6: An update changes only the selected counter. Counters of other entries, and counters of the same entry under other history patterns, keep their values.
- R7: No tag is stored. Addresses that differ only in bits outside [5:2] share the same entry and get the same prediction.
- R8: When a prediction and an update happen in the same cycle, the prediction is taken from the state before that update.
- R9: In a cycle with no update, no counter and no history bit changes, so the prediction for a held address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| predPc | input | 32 | Address of the branch being predicted |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| updValid | input | 1 | Resolved-branch update strobe |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Prediction and update can fall in the same cycle. When they do, the lookup must see the counters and the history as they were before the clock edge that applies the update. The stimulus table drives an update together with a prediction of the same address in almost every row. The bench samples predTaken one time unit after the inputs change, which is before the edge. Its hand-computed expectations therefore hold only if the answer reflects the pre-update counter and history. Rows in which the update moves the selected counter across its decision threshold show the difference directly.

// File: rtl/corr_pred_pkg.sv
package corr_pred_pkg;

  // Strobes sent from the control module to the counter table
  typedef struct packed {
    logic wrEn;   // a resolved branch updates the table this cycle
    logic incr;   // step the selected counter toward taken
    logic decr;   // step the selected counter toward not-taken
  } ctrStrobe_t;

endpackage

// File: rtl/corr_pred_ctrl.sv
module corr_pred_ctrl
  import corr_pred_pkg::*;
#(
  parameter int PC_WIDTH   = 32,
  parameter int ALIGN_BITS = 2,
  parameter int ENTRY_BITS = 4,
  parameter int HIST_BITS  = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [PC_WIDTH-1:0]             predPc,
  input  logic                            updValid,
  input  logic [PC_WIDTH-1:0]             updPc,
  input  logic                            updTaken,
  output logic [ENTRY_BITS+HIST_BITS-1:0] predIdx,
  output logic [ENTRY_BITS+HIST_BITS-1:0] updIdx,
  output ctrStrobe_t                      strobe
);

  localparam int PC_LO = ALIGN_BITS;
  localparam int PC_HI = ALIGN_BITS + ENTRY_BITS - 1;

  logic [ENTRY_BITS-1:0] predEntry;
  logic [ENTRY_BITS-1:0] updEntry;
  logic                  unusedPcBits;

  assign predEntry    = predPc[PC_HI:PC_LO];
  assign updEntry     = updPc[PC_HI:PC_LO];
  // Address bits outside the index are deliberately ignored (no tag)
  assign unusedPcBits = ^{predPc, updPc};

  always_comb begin
    strobe.wrEn = updValid;
    strobe.incr = updValid & updTaken;
    strobe.decr = updValid & ~updTaken;
  end

  generate
    if (HIST_BITS > 0) begin : g_hist
      logic [HIST_BITS-1:0] globalHist;

      if (HIST_BITS == 1) begin : g_one
        always_ff @(posedge clk) begin
          if (!rstN)         globalHist <= '0;
          else if (updValid) globalHist <= updTaken;
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (!rstN)         globalHist <= '0;
          else if (updValid) globalHist <= {globalHist[HIST_BITS-2:0], updTaken};
        end

        // R5: older outcomes move up by one position on each update
        assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
          updValid |=> globalHist[HIST_BITS-1:1] == $past(globalHist[HIST_BITS-2:0]));
      end

      assign predIdx = {predEntry, globalHist};
      assign updIdx  = {updEntry, globalHist};

      // R5: newest outcome lands in bit 0
      assert_hist_newest_R5: assert property (@(posedge clk) disable iff (!rstN)
        updValid |=> globalHist[0] == $past(updTaken));

      // R9: history holds when nothing resolves
      assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        !updValid |=> $stable(globalHist));
    end else begin : g_nohist
      assign predIdx = predEntry;
      assign updIdx  = updEntry;
    end
  endgenerate

  // R3: at most one counter direction is requested
  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.incr, strobe.decr}));

endmodule

// File: rtl/corr_pred_table.sv
module corr_pred_table
  import corr_pred_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int CTR_BITS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] predIdx,
  input  logic [IDX_W-1:0] updIdx,
  input  ctrStrobe_t       strobe,
  output logic             predTaken
);

  localparam int                DEPTH    = 1 << IDX_W;
  localparam logic [CTR_BITS-1:0] CTR_MAX  = '1;
  localparam logic [CTR_BITS-1:0] CTR_MIN  = '0;
  localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_BITS'((1 << (CTR_BITS - 1)) - 1);

  logic [CTR_BITS-1:0] ctrMem [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ctr
      logic hit;
      assign hit = strobe.wrEn && (updIdx == IDX_W'(e));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          ctrMem[e] <= CTR_INIT;
        end else if (hit) begin
          if (strobe.incr && ctrMem[e] != CTR_MAX)      ctrMem[e] <= ctrMem[e] + 1'b1;
          else if (strobe.decr && ctrMem[e] != CTR_MIN) ctrMem[e] <= ctrMem[e] - 1'b1;
        end
      end
    end
  endgenerate

  assign predTaken = ctrMem[predIdx][CTR_BITS-1];

  // R3: a full counter stays full on a taken outcome
  assert_sat_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && ctrMem[updIdx] == CTR_MAX) |=> ctrMem[$past(updIdx)] == CTR_MAX);

  // R3: an empty counter stays empty on a not-taken outcome
  assert_sat_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decr && ctrMem[updIdx] == CTR_MIN) |=> ctrMem[$past(updIdx)] == CTR_MIN);

  // R3: below the top, a taken outcome moves the counter up by exactly one
  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && ctrMem[updIdx] != CTR_MAX)
      |=> ctrMem[$past(updIdx)] == CTR_BITS'($past(ctrMem[updIdx]) + 1'b1));

  // R3: above the bottom, a not-taken outcome moves the counter down by exactly one
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decr && ctrMem[updIdx] != CTR_MIN)
      |=> ctrMem[$past(updIdx)] == CTR_BITS'($past(ctrMem[updIdx]) - 1'b1));

endmodule

// File: rtl/corr_predictor.sv
module corr_predictor
  import corr_pred_pkg::*;
#(
  parameter int PC_WIDTH   = 32,
  parameter int ALIGN_BITS = 2,
  parameter int ENTRY_BITS = 4,
  parameter int HIST_BITS  = 2,
  parameter int CTR_BITS   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PC_WIDTH-1:0] predPc,
  output logic                predTaken,
  input  logic                updValid,
  input  logic [PC_WIDTH-1:0] updPc,
  input  logic                updTaken
);

  localparam int IDX_W = ENTRY_BITS + HIST_BITS;

  logic [IDX_W-1:0] predIdx;
  logic [IDX_W-1:0] updIdx;
  ctrStrobe_t       strobe;

  corr_pred_ctrl #(
    .PC_WIDTH  (PC_WIDTH),
    .ALIGN_BITS(ALIGN_BITS),
    .ENTRY_BITS(ENTRY_BITS),
    .HIST_BITS (HIST_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .predPc  (predPc),
    .updValid(updValid),
    .updPc   (updPc),
    .updTaken(updTaken),
    .predIdx (predIdx),
    .updIdx  (updIdx),
    .strobe  (strobe)
  );

  corr_pred_table #(
    .IDX_W   (IDX_W),
    .CTR_BITS(CTR_BITS)
  ) u_table (
    .clk      (clk),
    .rstN     (rstN),
    .predIdx  (predIdx),
    .updIdx   (updIdx),
    .strobe   (strobe),
    .predTaken(predTaken)
  );

  // R9: with no update and a held address, the answer is held
  assert_pred_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> (!$stable(predPc) || $stable(predTaken)));

endmodule

// File: tb/sim_corr_predictor.sv
module sim_corr_predictor;

  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] predPc;
  logic        predTaken;
  logic        updValid;
  logic [31:0] updPc;
  logic        updTaken;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_predictor u0 (
    .clk      (clk),
    .rstN     (rstN),
    .predPc   (predPc),
    .predTaken(predTaken),
    .updValid (updValid),
    .updPc    (updPc),
    .updTaken (updTaken)
  );

  // Row layout: [11:8] requirement number, [7] update, [6] outcome,
  // [5] expected prediction before this row's update, [3:0] entry index.
  // Both ports use the same address in each row.
  localparam int NVEC = 16;
  localparam logic [11:0] VEC [NVEC] = '{
    12'h2_C3,  // R2  c[3,00]=1 -> 0, becomes 2
    12'h5_C3,  // R5  c[3,01]=1 -> 0, becomes 2
    12'h5_C3,  // R5  c[3,11]=1 -> 0, becomes 2
    12'h3_E3,  // R3  c[3,11]=2 -> 1, becomes 3
    12'h3_E3,  // R3  c[3,11]=3 stays 3
    12'h8_A3,  // R8  reads 3 before it drops to 2, history -> 10
    12'h5_83,  // R5  c[3,10]=1 -> 0, becomes 0, history -> 00
    12'h3_A3,  // R3  c[3,00]=2 -> 1, becomes 1
    12'h4_83,  // R4  c[3,00]=1 -> 0 after one miss from weak taken
    12'h3_83,  // R3  c[3,00]=0 stays 0
    12'h6_C5,  // R6  c[5,00]=1 -> 0, history -> 01
    12'h9_05,  // R9  no update, c[5,01]=1 -> 0
    12'h9_C5,  // R9  history still 01, c[5,01]=1 -> 0, history -> 11
    12'h5_C5,  // R5  c[5,11]=1 -> 0, becomes 2
    12'h2_25,  // R2  c[5,11]=2 -> 1, no update
    12'h4_23   // R4  c[3,11]=2 after one miss from 3 -> still taken
  };

  function automatic logic [31:0] pcOf(input logic [3:0] ent);
    return {26'd0, ent, 2'b00};
  endfunction

  task automatic checkPred(input logic exp, input string req, input string what);
    checks++;
    if (predTaken !== exp) begin
      errors++;
      $display("FAIL %s %s: predTaken=%0b expected=%0b", req, what, predTaken, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 time unit later, update applies at the rising edge
  task automatic step(input logic upd, input logic tk, input logic [31:0] uPc,
                      input logic [31:0] pPc, input logic exp, input string req,
                      input string what);
    @(negedge clk);
    updValid = upd;
    updTaken = tk;
    updPc    = uPc;
    predPc   = pPc;
    #1;
    checkPred(exp, req, what);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN     = 1'b0;
    updValid = 1'b0;
    updTaken = 1'b0;
    updPc    = '0;
    predPc   = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sweepNotTaken(input string what);
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b0, '0, pcOf(4'(i)), 1'b0, "R1", what);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();

    // R1: every entry predicts not-taken after reset
    sweepNotTaken("reset state");

    // Table walk, covering R2 R3 R4 R5 R6 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][7], VEC[v][6], pcOf(VEC[v][3:0]), pcOf(VEC[v][3:0]), VEC[v][5],
           $sformatf("R%0d", VEC[v][11:8]), $sformatf("vector %0d", v));
    end
    // History is now 11

    // R7: aliasing through upper and byte-offset address bits
    step(1'b0, 1'b0, '0, 32'h0000_100C, 1'b1, "R7", "upper bits alias entry 3");
    step(1'b0, 1'b0, '0, 32'hFFF0_000F, 1'b1, "R7", "offset bits alias entry 3");
    // R6: an untouched entry is still at its reset value
    step(1'b0, 1'b0, '0, pcOf(4'd7), 1'b0, "R6", "entry 7 untouched");

    // R5: updates on entry 0 steer which counter of entry 3 is used
    step(1'b1, 1'b0, pcOf(4'd0), pcOf(4'd3), 1'b1, "R5", "hist 11 selects c[3,11]=2");
    step(1'b1, 1'b0, pcOf(4'd0), pcOf(4'd3), 1'b0, "R5", "hist 10 selects c[3,10]=0");
    step(1'b1, 1'b1, pcOf(4'd0), pcOf(4'd3), 1'b0, "R5", "hist 00 selects c[3,00]=0");
    step(1'b0, 1'b0, '0,         pcOf(4'd3), 1'b1, "R5", "hist 01 selects c[3,01]=2");
    // R6: entry 0 updates did not disturb entry 5
    step(1'b0, 1'b0, '0, pcOf(4'd5), 1'b1, "R6", "c[5,01]=2 intact");

    // R1: a later reset clears counters and history again
    doReset();
    sweepNotTaken("second reset");
    step(1'b1, 1'b1, pcOf(4'd9), pcOf(4'd3), 1'b0, "R1", "history cleared, c[3,00]=1");
    step(1'b0, 1'b0, '0,         pcOf(4'd3), 1'b0, "R1", "c[3,01] back to 1");
    step(1'b0, 1'b0, '0,         pcOf(4'd9), 1'b0, "R1", "c[9,01] back to 1");

    @(negedge clk);
    updValid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule